// File: doc/BRIEF.md
# Microprogram Sequencer with Jam Branching

This block is the control engine of a microcoded processor. A writable control store of 512 words, 36 bits each, holds the microprogram. A microprogram counter selects the next word, which is captured in a microinstruction register. The fields of that register drive the datapath directly: ALU and shifter controls, nine register load strobes for the result bus, three memory request bits, and a one-hot enable for the source bus.

Every microinstruction carries the address of its successor. A conditional branch is formed by ORing a latched flag into the top address bit, so the two targets sit 256 words apart. An opcode dispatch ORs an 8-bit byte register into the low eight bits. The negative and zero flags are captured on the rising clock edge. The next address is formed while the clock is high, and the microinstruction register loads on the falling edge.

A testbench or boot loader fills the control store through a simple write port.

Top module: `microSequencer`

## Requirements
- R1: While reset is held low, the counter reads 0 and the microinstruction register holds all zeros. In that state every load strobe, ALU bit and memory bit is 0, the source enable is 9'b000000001, and the conflict flag is 0.
- R2: When all three jump bits of the current word are clear, the next counter value equals the word's next-address field, bits 35:27. The flags and the byte input have no effect.
- R3: Bit 25 of the word is the N-jam. When it is set, the next address is the next-address field with bit 8 ORed with the latched N flag.
- R4: Bit 24 of the word is the Z-jam. When it is set, bit 8 of the next address is ORed with the latched Z flag. When both jam bits are set, both flags contribute.
- R5: Bit 26 of the word is the dispatch bit. When it is set, the 8-bit byte input is bitwise ORed into bits 7:0 of the next-address field.
- R6: The 4-bit source code in bits 3:0 drives `bEn`. Codes 0 to 8 each raise only bit `code` of `bEn`. Codes 9 to 15 raise none.
- R7: The outputs are taken straight from the current word. The ALU/shifter field (bits 23:16) appears on `aluCtl`. The nine load enables (bits 15:7) appear on `cLoad`. Write, read and fetch (bits 6, 5 and 4) appear on `memWrite`, `memRead` and `memFetch`.
- R8: `memConflict` is 1 exactly when the current word sets both read and write.
- R9: The N and Z flags are sampled at the rising edge. A change on `nIn` or `zIn` after that edge and before the following falling edge does not alter the branch taken.
- R10: The microinstruction register and the counter change only at falling edges. A word written through the store port is the word later fetched from that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; flags load on rise, microinstruction on fall |
| rstN | input | 1 | Asynchronous active-low reset |
| csWe | input | 1 | Control store write enable, taken at rising edge |
| csWaddr | input | 9 | Control store write address |
| csWdata | input | 36 | Control store write data |
| nIn | input | 1 | Negative flag from the ALU |
| zIn | input | 1 | Zero flag from the ALU |
| mbrIn | input | 8 | Fetched byte used for dispatch |
| mpcOut | output | 9 | Current microprogram counter |
| aluCtl | output | 8 | ALU and shifter control field |
| cLoad | output | 9 | Result-bus register load strobes |
| memWrite | output | 1 | Memory write request |
| memRead | output | 1 | Memory read request |
| memFetch | output | 1 | Byte fetch request |
| bEn | output | 9 | One-hot source-bus enable |
| memConflict | output | 1 | Read and write requested together |

## Verification
The hardest case to reach is the flag timing of R9. The flags must be latched at the rising edge, yet the next address is only consumed at the falling edge. A design that reads the live flag pins would pass every ordinary branch test. The stimulus therefore drives a Z-jam word and holds `zIn` at one value across the rising edge. It then flips `zIn` while the clock is high. The test is run in both polarities, and each time the branch must follow the value captured at the edge. Dispatch targets are chosen so that OR and addition give different answers.

// File: rtl/useqPkg.sv
package useqPkg;
  localparam int ADDR_W   = 9;
  localparam int WORD_W   = 36;
  localparam int BYTE_W   = 8;
  localparam int ALU_W    = 8;
  localparam int CLD_W    = 9;
  localparam int BSEL_W   = 4;
  localparam int NUM_BSRC = 9;
  localparam int DEPTH    = 1 << ADDR_W;

  // Field order is fixed: bits 35 down to 0.
  typedef struct packed {
    logic [ADDR_W-1:0] nextAddr;
    logic              jmpc;
    logic              jamN;
    logic              jamZ;
    logic [ALU_W-1:0]  alu;
    logic [CLD_W-1:0]  cEn;
    logic              memWr;
    logic              memRd;
    logic              memFetch;
    logic [BSEL_W-1:0] bCode;
  } microWord_t;

  // Strobes handed from the control side to the decode side.
  typedef struct packed {
    logic [ALU_W-1:0]  alu;
    logic [CLD_W-1:0]  cEn;
    logic              memWr;
    logic              memRd;
    logic              memFetch;
    logic [BSEL_W-1:0] bCode;
  } ctrlStrobes_t;
endpackage

// File: rtl/ctrlStore.sv
module ctrlStore
  import useqPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = WORD_W
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/seqCtrl.sv
module seqCtrl
  import useqPkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          csWe,
  input  logic [AW-1:0] csWaddr,
  input  logic [WORD_W-1:0] csWdata,
  input  logic          nIn,
  input  logic          zIn,
  input  logic [BW-1:0] mbrIn,
  output logic [AW-1:0] mpc,
  output microWord_t    curWord,
  output logic          nFlag,
  output logic          zFlag,
  output ctrlStrobes_t  strobes
);
  localparam int HI  = AW - 1;
  localparam int PAD = AW - BW;

  logic [AW-1:0]     nextMpc;
  logic [WORD_W-1:0] fetched;
  logic              hiJam;
  logic [BW-1:0]     loJam;

  // Flags are taken on the rising edge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      nFlag <= 1'b0;
      zFlag <= 1'b0;
    end else begin
      nFlag <= nIn;
      zFlag <= zIn;
    end
  end

  // Next address is settled while the clock is high.
  always_comb begin
    hiJam   = curWord.nextAddr[HI] | (curWord.jamN & nFlag) | (curWord.jamZ & zFlag);
    loJam   = curWord.nextAddr[BW-1:0] | (curWord.jmpc ? mbrIn : '0);
    nextMpc = curWord.nextAddr;
    nextMpc[HI] = hiJam;
    nextMpc[BW-1:0] = loJam;
  end

  ctrlStore #(.AW(AW), .DW(WORD_W)) u_store (
    .clk   (clk),
    .we    (csWe),
    .waddr (csWaddr),
    .wdata (csWdata),
    .raddr (nextMpc),
    .rdata (fetched)
  );

  // Counter and microinstruction register load on the falling edge.
  always_ff @(negedge clk or negedge rstN) begin
    if (!rstN) begin
      mpc     <= '0;
      curWord <= '0;
    end else begin
      mpc     <= nextMpc;
      curWord <= microWord_t'(fetched);
    end
  end

  always_comb begin
    strobes.alu      = curWord.alu;
    strobes.cEn      = curWord.cEn;
    strobes.memWr    = curWord.memWr;
    strobes.memRd    = curWord.memRd;
    strobes.memFetch = curWord.memFetch;
    strobes.bCode    = curWord.bCode;
  end

  if (PAD < 1) begin : g_badWidth
    initial $error("address must be wider than the dispatch byte");
  end
endmodule

// File: rtl/fieldDecode.sv
module fieldDecode
  import useqPkg::*;
#(
  parameter int NB = NUM_BSRC
) (
  input  ctrlStrobes_t     strobes,
  output logic [ALU_W-1:0] aluCtl,
  output logic [CLD_W-1:0] cLoad,
  output logic             memWrite,
  output logic             memRead,
  output logic             memFetch,
  output logic [NB-1:0]    bEn,
  output logic             memConflict
);
  assign aluCtl   = strobes.alu;
  assign cLoad    = strobes.cEn;
  assign memWrite = strobes.memWr;
  assign memRead  = strobes.memRd;
  assign memFetch = strobes.memFetch;

  // Only the first NB codes name a source; the rest enable nothing.
  for (genvar i = 0; i < NB; i++) begin : g_bsrc
    assign bEn[i] = (strobes.bCode == BSEL_W'(i));
  end

  assign memConflict = strobes.memRd & strobes.memWr;
endmodule

// File: rtl/microSequencer.sv
module microSequencer
  import useqPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              csWe,
  input  logic [ADDR_W-1:0] csWaddr,
  input  logic [WORD_W-1:0] csWdata,
  input  logic              nIn,
  input  logic              zIn,
  input  logic [BYTE_W-1:0] mbrIn,
  output logic [ADDR_W-1:0] mpcOut,
  output logic [ALU_W-1:0]  aluCtl,
  output logic [CLD_W-1:0]  cLoad,
  output logic              memWrite,
  output logic              memRead,
  output logic              memFetch,
  output logic [NUM_BSRC-1:0] bEn,
  output logic              memConflict
);
  microWord_t   curWord;
  ctrlStrobes_t strobes;
  logic         nFlag;
  logic         zFlag;
  logic [ADDR_W-1:0] wordNext;
  logic [2:0]        wordJam;

  seqCtrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .csWe    (csWe),
    .csWaddr (csWaddr),
    .csWdata (csWdata),
    .nIn     (nIn),
    .zIn     (zIn),
    .mbrIn   (mbrIn),
    .mpc     (mpcOut),
    .curWord (curWord),
    .nFlag   (nFlag),
    .zFlag   (zFlag),
    .strobes (strobes)
  );

  fieldDecode u_dec (
    .strobes     (strobes),
    .aluCtl      (aluCtl),
    .cLoad       (cLoad),
    .memWrite    (memWrite),
    .memRead     (memRead),
    .memFetch    (memFetch),
    .bEn         (bEn),
    .memConflict (memConflict)
  );

  assign wordNext = curWord.nextAddr;
  assign wordJam  = {curWord.jmpc, curWord.jamN, curWord.jamZ};
endmodule

// File: rtl/microSequencerChk.sv
module microSequencerChk (
  input logic       clk,
  input logic       rstN,
  input logic [8:0] wordNext,
  input logic [2:0] wordJam,
  input logic       nFlag,
  input logic       zFlag,
  input logic [7:0] mbrIn,
  input logic [8:0] mpcOut,
  input logic [8:0] bEn,
  input logic       memRead,
  input logic       memWrite,
  input logic       memConflict
);
  AST_PLAIN_NEXT: assert property (@(negedge clk) disable iff (!rstN)
    ($past(wordJam) == 3'b000) |-> (mpcOut == $past(wordNext))); // R2

  AST_JAMN_HIGH: assert property (@(negedge clk) disable iff (!rstN)
    ($past(wordJam[1]) && $past(nFlag)) |-> mpcOut[8]); // R3

  AST_JAMZ_HIGH: assert property (@(negedge clk) disable iff (!rstN)
    ($past(wordJam[0]) && $past(zFlag)) |-> mpcOut[8]); // R4

  AST_DISPATCH_OR: assert property (@(negedge clk) disable iff (!rstN)
    $past(wordJam[2]) |-> ((mpcOut[7:0] & $past(mbrIn)) == $past(mbrIn))); // R5

  AST_BSRC_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(bEn)); // R6

  AST_RW_CONFLICT: assert property (@(posedge clk) disable iff (!rstN)
    memConflict |-> (memRead && memWrite)); // R8
endmodule

bind microSequencer microSequencerChk u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .wordNext    (wordNext),
  .wordJam     (wordJam),
  .nFlag       (nFlag),
  .zFlag       (zFlag),
  .mbrIn       (mbrIn),
  .mpcOut      (mpcOut),
  .bEn         (bEn),
  .memRead     (memRead),
  .memWrite    (memWrite),
  .memConflict (memConflict)
);

// File: tb/sim_microSequencer.sv
module sim_microSequencer;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csWe = 1'b0;
  logic [8:0]  csWaddr = '0;
  logic [35:0] csWdata = '0;
  logic        nIn = 1'b0;
  logic        zIn = 1'b0;
  logic [7:0]  mbrIn = '0;
  logic [8:0]  mpcOut;
  logic [7:0]  aluCtl;
  logic [8:0]  cLoad;
  logic        memWrite, memRead, memFetch;
  logic [8:0]  bEn;
  logic        memConflict;

  int checks = 0;
  int errors = 0;
  logic [35:0] img [512];

  always #4 clk = ~clk;

  microSequencer u0 (
    .clk(clk), .rstN(rstN), .csWe(csWe), .csWaddr(csWaddr), .csWdata(csWdata),
    .nIn(nIn), .zIn(zIn), .mbrIn(mbrIn), .mpcOut(mpcOut), .aluCtl(aluCtl),
    .cLoad(cLoad), .memWrite(memWrite), .memRead(memRead), .memFetch(memFetch),
    .bEn(bEn), .memConflict(memConflict)
  );

  function automatic logic [35:0] mk(input logic [8:0] nxt, input logic [2:0] jam,
      input logic [7:0] alu, input logic [8:0] c, input logic [2:0] mem, input logic [3:0] b);
    return {nxt, jam, alu, c, mem, b};
  endfunction

  function automatic logic [8:0] expB(input logic [3:0] code);
    return (code < 4'd9) ? (9'd1 << code) : 9'd0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic loadWord(input logic [8:0] a, input logic [35:0] w);
    img[a] = w;
    csWe = 1'b1; csWaddr = a; csWdata = w;
    @(posedge clk); #1;
    csWe = 1'b0;
  endtask

  task automatic checkAt(input logic [8:0] a);
    logic [35:0] w;
    w = img[a];
    chk("R2 R3 R4 R5 next address", 64'(mpcOut), 64'(a));
    chk("R7 alu field", 64'(aluCtl), 64'(w[23:16]));
    chk("R7 load strobes", 64'(cLoad), 64'(w[15:7]));
    chk("R7 memory bits", 64'({memWrite, memRead, memFetch}), 64'(w[6:4]));
    chk("R6 source enable", 64'(bEn), 64'(expB(w[3:0])));
    chk("R8 conflict", 64'(memConflict), 64'(w[6] & w[5]));
  endtask

  task automatic doReset();
    @(negedge clk); #1;
    rstN = 1'b0;
    @(negedge clk); @(negedge clk); #1;
    rstN = 1'b1;
    @(negedge clk); #1;
  endtask

  task automatic step(input logic n, input logic z, input logic [7:0] b, input logic [8:0] a);
    nIn = n; zIn = z; mbrIn = b;
    @(negedge clk); #1;
    checkAt(a);
  endtask

  // {n, z, mbr, expected next address}
  localparam logic [18:0] VEC [10] = '{
    {1'b0, 1'b0, 8'h00, 9'h005},
    {1'b0, 1'b1, 8'h00, 9'h110},
    {1'b0, 1'b0, 8'h00, 9'h020},
    {1'b0, 1'b0, 8'h3C, 9'h03C},
    {1'b0, 1'b0, 8'h03, 9'h043},
    {1'b1, 1'b1, 8'h00, 9'h107},
    {1'b0, 1'b0, 8'h00, 9'h000},
    {1'b1, 1'b0, 8'hFF, 9'h005},
    {1'b1, 1'b0, 8'h00, 9'h010},
    {1'b0, 1'b0, 8'h00, 9'h000}
  };

  initial begin
    #(8 * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 512; i++) img[i] = '0;
    #1;
    loadWord(9'h000, mk(9'h005, 3'b000, 8'hA5, 9'h101, 3'b001, 4'd3));
    loadWord(9'h005, mk(9'h010, 3'b001, 8'h3C, 9'h0F0, 3'b010, 4'd8));
    loadWord(9'h110, mk(9'h020, 3'b010, 8'h81, 9'h002, 3'b100, 4'd9));
    loadWord(9'h020, mk(9'h000, 3'b100, 8'h00, 9'h1FF, 3'b110, 4'd0));
    loadWord(9'h03C, mk(9'h041, 3'b100, 8'h5A, 9'h040, 3'b000, 4'd5));
    loadWord(9'h043, mk(9'h007, 3'b011, 8'hFF, 9'h000, 3'b000, 4'd7));
    loadWord(9'h107, mk(9'h000, 3'b000, 8'h12, 9'h008, 3'b001, 4'd15));
    loadWord(9'h010, mk(9'h000, 3'b000, 8'h34, 9'h100, 3'b010, 4'd1));

    // R1: state while reset is held
    chk("R1 counter", 64'(mpcOut), 64'h0);
    chk("R1 strobes", 64'({aluCtl, cLoad, memWrite, memRead, memFetch}), 64'h0);
    chk("R1 source enable", 64'(bEn), 64'h1);
    chk("R1 conflict", 64'(memConflict), 64'h0);

    @(negedge clk); #1;
    rstN = 1'b1;
    @(negedge clk); #1;
    checkAt(9'h000); // R10 first word loaded at falling edge

    foreach (VEC[i]) step(VEC[i][18], VEC[i][17], VEC[i][16:9], VEC[i][8:0]);

    // R9: Z held high at the rising edge, dropped while clock is high
    doReset();
    step(1'b0, 1'b0, 8'h00, 9'h005);
    zIn = 1'b1;
    @(posedge clk); #1;
    zIn = 1'b0;
    chk("R10 counter held across rising edge", 64'(mpcOut), 64'h005);
    chk("R10 strobes held across rising edge", 64'(cLoad), 64'h0F0);
    @(negedge clk); #1;
    chk("R9 flag sampled at rising edge (taken)", 64'(mpcOut), 64'h110);

    // R9: Z low at the rising edge, raised while clock is high
    doReset();
    step(1'b0, 1'b0, 8'h00, 9'h005);
    zIn = 1'b0;
    @(posedge clk); #1;
    zIn = 1'b1;
    @(negedge clk); #1;
    chk("R9 flag sampled at rising edge (not taken)", 64'(mpcOut), 64'h010);
    zIn = 1'b0;

    // R10: rewrite a word, then fetch it
    doReset();
    loadWord(9'h010, mk(9'h000, 3'b000, 8'hC3, 9'h0AA, 3'b000, 4'd2));
    @(negedge clk); #1;
    doReset();
    step(1'b0, 1'b0, 8'h00, 9'h005);
    step(1'b0, 1'b0, 8'h00, 9'h010);
    chk("R10 rewritten word fetched", 64'(cLoad), 64'h0AA);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule